// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block performs the register context changes of a stackless 16-bit processor. The processor holds only three internal registers: the program counter, the status word and a workspace pointer. General register n is not kept on chip. It is the memory word at the workspace pointer plus 2·n. Switching context therefore means pointing the workspace pointer at a different region of memory, and saving the old pointer, counter and status into three fixed slots of the new region.

The sequencer handles three operations. A branch command arrives as a one-cycle pulse with a vector address. The vector is a pair of words: the new workspace pointer, then the new program counter. The sequencer fetches both words. It then stores the old workspace pointer, program counter and status into registers 13, 14 and 15 of the new workspace, and commits the new values.

A return command reads those three slots of the current workspace, last slot first, and restores status, counter and pointer. An interrupt performs the same switch as a branch. A maskable request supplies a 4-bit level, which selects one of sixteen vectors at the bottom of memory. A non-maskable request uses a dedicated vector at the top of memory. All memory traffic goes through one word-wide request/acknowledge port.

Top module: `ctx_switch_seq`

## Requirements
- R1: After reset, `wp`, `pc` and `st` are zero, and `busy`, `done` and `mem_req` are low.
- R2: A branch, an interrupt or a non-maskable entry reads the new workspace pointer from the vector address V, then reads the new program counter from V+2. Both reads have `mem_we` low.
- R3: After the vector fetch, the block writes the old `wp` to new-workspace + 26, the old `pc` to new-workspace + 28 and the old `st` to new-workspace + 30, in that order. Only then do `wp` and `pc` take the fetched values. A branch leaves `st` unchanged.
- R4: A return makes three reads of the current workspace: offset 30 into `st`, offset 28 into `pc`, and offset 26 into `wp`, in that order. `wp` changes only at the end of the return.
- R5: With the block idle, a maskable request is accepted when `irq_lvl` is less than or equal to `st[3:0]`. Its vector address is `irq_lvl`·4.
- R6: When a maskable entry completes, `st[3:0]` becomes `irq_lvl`−1, or stays 0 when the level was 0. The bits `st[15:4]` keep their old value. The word saved at offset 30 is the status from before this update.
- R7: A maskable request with `irq_lvl` greater than `st[3:0]` is not taken. `busy` stays low and no memory access occurs.
- R8: `nmi_req` overrides any maskable request. It uses the vector at 0xFFFC/0xFFFE and leaves `st` unchanged.
- R9: When the block is idle, it picks one start in priority order: non-maskable, then maskable, then branch, then return. `call_req` and `ret_req` pulses that arrive while `busy` is high are ignored.
- R10: `mem_req` stays high, with address, write enable and write data unchanged, until `mem_ack`. `busy` is high from the cycle after a start until the sequence ends. `done` is a one-cycle pulse seen with `busy` low, in the cycle after the final access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Branch start pulse |
| call_vec | input | 16 | Vector address for branch |
| ret_req | input | 1 | Return start pulse |
| irq_req | input | 1 | Maskable interrupt request (level) |
| irq_lvl | input | 4 | Maskable interrupt level |
| nmi_req | input | 1 | Non-maskable interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (one cycle) |
| wp | output | 16 | Workspace pointer |
| pc | output | 16 | Program counter |
| st | output | 16 | Status word, mask in bits 3:0 |

## Verification
The assertions take for granted that every vector address, every fetched workspace pointer and the reset pointer are even. Under that assumption all word accesses stay aligned. They also take for granted that `mem_ack` is given only while `mem_req` is high.

The memory model in the bench answers requests with a varying number of wait cycles and raises acknowledge only on an open request. Every vector and workspace value the bench places in memory is even. Interrupt requests are held until `busy` rises or the rejection window closes, so sampling between operations is exercised and never interrupted mid-sequence.

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq #(
  parameter logic [15:0] NMI_VEC = 16'hFFFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        call_req,
  input  logic [15:0] call_vec,
  input  logic        ret_req,
  input  logic        irq_req,
  input  logic [3:0]  irq_lvl,
  input  logic        nmi_req,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ack,
  output logic        busy,
  output logic        done,
  output logic [15:0] wp,
  output logic [15:0] pc,
  output logic [15:0] st
);
  typedef enum logic [3:0] {
    IDLE, VEC_WP, VEC_PC, SAV13, SAV14, SAV15, RES15, RES14, RES13
  } state_t;

  state_t      state;
  logic [15:0] vaddr, nwp, npc;
  logic        from_irq;
  logic [3:0]  lvl_q;

  wire irq_ok = irq_req && (irq_lvl <= st[3:0]);
  wire [3:0] new_mask = (lvl_q == 4'd0) ? 4'd0 : lvl_q - 4'd1;

  assign busy    = (state != IDLE);
  assign mem_req = busy;
  assign mem_we  = (state == SAV13) || (state == SAV14) || (state == SAV15);

  always_comb begin
    mem_addr  = 16'h0000;
    mem_wdata = 16'h0000;
    case (state)
      VEC_WP: mem_addr = vaddr;
      VEC_PC: mem_addr = vaddr + 16'd2;
      SAV13:  begin mem_addr = nwp + 16'd26; mem_wdata = wp; end
      SAV14:  begin mem_addr = nwp + 16'd28; mem_wdata = pc; end
      SAV15:  begin mem_addr = nwp + 16'd30; mem_wdata = st; end
      RES15:  mem_addr = wp + 16'd30;
      RES14:  mem_addr = wp + 16'd28;
      RES13:  mem_addr = wp + 16'd26;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      wp       <= '0;
      pc       <= '0;
      st       <= '0;
      vaddr    <= '0;
      nwp      <= '0;
      npc      <= '0;
      from_irq <= 1'b0;
      lvl_q    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: begin
          if (nmi_req) begin
            vaddr <= NMI_VEC; from_irq <= 1'b0; state <= VEC_WP;
          end else if (irq_ok) begin
            vaddr <= {10'b0, irq_lvl, 2'b00}; lvl_q <= irq_lvl;
            from_irq <= 1'b1; state <= VEC_WP;
          end else if (call_req) begin
            vaddr <= call_vec; from_irq <= 1'b0; state <= VEC_WP;
          end else if (ret_req) begin
            state <= RES15;
          end
        end
        VEC_WP: if (mem_ack) begin nwp <= mem_rdata; state <= VEC_PC; end
        VEC_PC: if (mem_ack) begin npc <= mem_rdata; state <= SAV13; end
        SAV13:  if (mem_ack) state <= SAV14;
        SAV14:  if (mem_ack) state <= SAV15;
        SAV15:  if (mem_ack) begin
          wp    <= nwp;
          pc    <= npc;
          if (from_irq) st[3:0] <= new_mask;
          done  <= 1'b1;
          state <= IDLE;
        end
        RES15:  if (mem_ack) begin npc <= mem_rdata; state <= RES14; end
        RES14:  if (mem_ack) begin pc <= mem_rdata; st <= npc; state <= RES13; end
        RES13:  if (mem_ack) begin wp <= mem_rdata; done <= 1'b1; state <= IDLE; end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_switch_seq_chk.sv
module ctx_switch_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        call_req,
  input logic        ret_req,
  input logic        irq_req,
  input logic [3:0]  irq_lvl,
  input logic        nmi_req,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ack,
  input logic        busy,
  input logic        done,
  input logic [15:0] wp,
  input logic [15:0] st
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seen && mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seen && done |-> !busy && $past(busy)); // R10
  AST_WP_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !done |-> $stable(wp)); // R4
  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]); // R2
  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !busy && irq_req && (irq_lvl > st[3:0]) && !nmi_req && !call_req && !ret_req |=> !busy); // R7
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !busy && nmi_req |=> mem_addr == 16'hFFFC && !mem_we); // R8
endmodule

bind ctx_switch_seq ctx_switch_seq_chk chk_i (.*);

// File: tb/ctx_switch_seq_tb_top.sv
module ctx_switch_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_req = 1'b0, ret_req = 1'b0, irq_req = 1'b0, nmi_req = 1'b0;
  logic [15:0] call_vec = '0;
  logic [3:0]  irq_lvl = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0, busy, done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0, wp, pc, st;

  always #5 clk = ~clk;

  ctx_switch_seq dut_i (.*);

  typedef struct { logic [15:0] addr; logic we; logic [15:0] data; string tag; } tr_t;
  tr_t exp_q[$];
  logic [15:0] mem [logic [15:0]];
  int checks = 0, fails = 0;
  int wcnt = 0, wseed = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic w, input logic [15:0] d, input string tag);
    tr_t t;
    t.addr = a; t.we = w; t.data = d; t.tag = tag;
    exp_q.push_back(t);
  endtask

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wcnt == 0) begin
        mem_ack = 1'b1;
        mem_rdata = rd(mem_addr);
        wseed++;
        wcnt = wseed % 3;
      end else wcnt--;
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected access", mem_addr, 16'hxxxx);
      else begin
        tr_t t;
        t = exp_q.pop_front();
        chk(mem_addr == t.addr && mem_we == t.we, t.tag, mem_addr, t.addr);
        if (t.we) chk(mem_wdata == t.data, t.tag, mem_wdata, t.data);
      end
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  task automatic expect_switch(input logic [15:0] v, input logic [15:0] ow, input logic [15:0] op, input logic [15:0] os);
    logic [15:0] nw;
    nw = rd(v);
    push(v, 0, 0, "R2 vector wp");
    push(v + 16'd2, 0, 0, "R2 vector pc");
    push(nw + 16'd26, 1, ow, "R3 save wp");
    push(nw + 16'd28, 1, op, "R3 save pc");
    push(nw + 16'd30, 1, os, "R3 save st");
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    chk(!busy, "R10 done with busy low", {15'b0, busy}, 16'h0);
    chk(exp_q.size() == 0, "R10 all accesses done", exp_q.size(), 16'h0);
  endtask

  task automatic regs(input logic [15:0] ew, input logic [15:0] ep, input logic [15:0] es, input string tag);
    chk(wp == ew, tag, wp, ew);
    chk(pc == ep, tag, pc, ep);
    chk(st == es, tag, st, es);
  endtask

  task automatic pulse_call(input logic [15:0] v);
    call_vec = v; call_req = 1'b1;
    @(negedge clk); call_req = 1'b0;
    chk(busy, "R10 busy after start", {15'b0, busy}, 16'h1);
  endtask

  initial begin
    mem[16'h0100] = 16'h2000; mem[16'h0102] = 16'h0400;
    mem[16'h0014] = 16'h4000; mem[16'h0016] = 16'h0500;
    mem[16'h0000] = 16'h5000; mem[16'h0002] = 16'h0600;
    mem[16'hFFFC] = 16'h6000; mem[16'hFFFE] = 16'h0700;
    mem[16'h0200] = 16'h7000; mem[16'h0202] = 16'h0800;
    mem[16'h0300] = 16'h7800; mem[16'h0302] = 16'h0900;
    repeat (3) @(negedge clk);
    regs(16'h0, 16'h0, 16'h0, "R1 reset regs");
    chk(!busy && !done && !mem_req, "R1 reset ctrl", {13'b0, busy, done, mem_req}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    expect_switch(16'h0100, 16'h0, 16'h0, 16'h0);
    pulse_call(16'h0100);
    wait_done();
    regs(16'h2000, 16'h0400, 16'h0000, "R3 branch commit");

    mem[16'h201E] = 16'h800F; mem[16'h201C] = 16'h1234; mem[16'h201A] = 16'h3000;
    push(16'h201E, 0, 0, "R4 read st slot");
    push(16'h201C, 0, 0, "R4 read pc slot");
    push(16'h201A, 0, 0, "R4 read wp slot");
    ret_req = 1'b1; @(negedge clk); ret_req = 1'b0;
    wait_done();
    regs(16'h3000, 16'h1234, 16'h800F, "R4 return restore");

    expect_switch(16'h0014, 16'h3000, 16'h1234, 16'h800F);
    irq_lvl = 4'd5; irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    wait_done();
    regs(16'h4000, 16'h0500, 16'h8004, "R5 R6 irq level 5");

    irq_lvl = 4'd5; irq_req = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(!busy && !mem_req, "R7 equal level blocked", {15'b0, busy}, 16'h0);
    end
    irq_lvl = 4'd9;
    repeat (4) begin
      @(negedge clk);
      chk(!busy, "R7 lower level blocked", {15'b0, busy}, 16'h0);
    end
    irq_req = 1'b0;
    regs(16'h4000, 16'h0500, 16'h8004, "R7 state kept");

    expect_switch(16'h0000, 16'h4000, 16'h0500, 16'h8004);
    irq_lvl = 4'd0; irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    wait_done();
    regs(16'h5000, 16'h0600, 16'h8000, "R6 level 0 mask");

    expect_switch(16'hFFFC, 16'h5000, 16'h0600, 16'h8000);
    irq_lvl = 4'd0; irq_req = 1'b1; nmi_req = 1'b1; call_vec = 16'h0100; call_req = 1'b1;
    @(negedge clk); irq_req = 1'b0; nmi_req = 1'b0; call_req = 1'b0;
    wait_done();
    regs(16'h6000, 16'h0700, 16'h8000, "R8 nmi wins, st kept");

    expect_switch(16'h0200, 16'h6000, 16'h0700, 16'h8000);
    pulse_call(16'h0200);
    call_vec = 16'h0100; call_req = 1'b1; ret_req = 1'b1;
    @(negedge clk); call_req = 1'b0; ret_req = 1'b0;
    wait_done();
    regs(16'h7000, 16'h0800, 16'h8000, "R9 busy ignores starts");

    expect_switch(16'h0300, 16'h7000, 16'h0800, 16'h8000);
    call_vec = 16'h0300; call_req = 1'b1; ret_req = 1'b1;
    @(negedge clk); call_req = 1'b0; ret_req = 1'b0;
    wait_done();
    regs(16'h7800, 16'h0900, 16'h8000, "R9 branch before return");

    repeat (8) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R9 stays idle", {15'b0, busy}, 16'h0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule